// File: doc/BRIEF.md
# Walk Entry Cache

This block is a small set-associative store of page-table words for an accelerator's address-validation walker. There is no separate translation buffer in front of it. Each fetch of a table word during a walk is looked up by the physical address of that word. A hit returns the full 64-bit word straight away. A walk that hits at every level therefore finishes without any main-memory traffic. The walker fills misses with words it has read from table memory.

The cache does not interpret the words it holds. Upper-level directory words, last-level entries and compact permission words all share the same storage. Each is identified only by where it sits in memory. With the default parameters there are 32 sets of 4 ways, which gives 128 words, or 1 KB of data. A single flush input empties the whole array when the operating system changes its tables.

Top module: `walk_entry_cache`

## Requirements
- R1: After reset every way is empty, `lkp_done` is low and every lookup misses.
- R2: A lookup that is requested at a clock edge reports `lkp_done` high in the following cycle, and `lkp_done` is low in every other cycle. A new lookup may be issued every cycle, so four chained lookups that all hit complete in four consecutive cycles.
- R3: A lookup that hits returns the 64-bit word most recently filled at that address, whatever kind of table word it is. A lookup that misses returns zero on `lkp_data`.
- R4: The set is selected by address bits [7:3], and the tag is made of the bits above bit 7. Address bits [2:0] are ignored, so a word is found through any byte address inside its 8-byte slot. Two addresses that differ only in the set bits do not alias.
- R5: A fill to an address that is already held overwrites that way in place. An address is never held in two ways.
- R6: A fill to an address that is not held goes into the lowest-numbered empty way of its set when one exists.
- R7: When the set is full, the fill replaces the way chosen by a 3-bit tree pseudo-LRU. The root bit selects the way pair: 0 selects ways 0/1 and 1 selects ways 2/3. The pair bit then selects the way: 0 selects the lower way and 1 selects the upper way. Each hit and each fill makes the bits point away from the way it used. Reset and flush clear all three bits.
- R8: When `flush` is high at an edge, every way becomes empty and every replacement state is cleared. A fill in the same cycle is discarded, and a lookup in the same cycle reports a miss.
- R9: A lookup and a fill in the same cycle act as follows. The lookup sees the contents as they were before the fill. If both target one set, only the fill updates that set's replacement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_req | input | 1 | Lookup request |
| lkp_addr | input | ADDR_W | Physical address of the table word to look up |
| lkp_done | output | 1 | Lookup result valid, one cycle after the request |
| lkp_hit | output | 1 | The looked-up word is present |
| lkp_data | output | DATA_W | Word returned on a hit, zero on a miss |
| fill_en | input | 1 | Write a word fetched from table memory |
| fill_addr | input | ADDR_W | Physical address of the word being filled |
| fill_data | input | DATA_W | Table word being filled |
| flush | input | 1 | Invalidate every entry |

## Verification
Directed sequences handle the following cases:
- Hits through unaligned byte addresses separate correct use of the offset bits from correct use of the index bits.
- Refills of a held address tell in-place overwrite apart from duplicate allocation.
- Filling four tags into one set and then a fifth, with hits placed in between, shows whether the victim follows the pseudo-LRU order or only the fill order.
- Flushes that coincide with lookups and fills check what the same-cycle rules say about those overlaps.
- Four back-to-back lookups that mimic a full walk show single-cycle throughput.

Random traffic confined to four sets and six tags then keeps the sets under constant eviction pressure, with lookups, fills, overlapping pairs and occasional flushes. A bench model checks the result of every lookup.

// File: rtl/walk_entry_cache.sv
module walk_entry_cache #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int SETS   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_req,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_done,
  output logic              lkp_hit,
  output logic [DATA_W-1:0] lkp_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              flush
);
  localparam int WAYS  = 4;
  localparam int OFF_W = 3;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [WAYS-1:0]   vld   [SETS];
  logic [2:0]        plru  [SETS];
  logic [TAG_W-1:0]  tags  [SETS][WAYS];
  logic [DATA_W-1:0] words [SETS][WAYS];

  wire [IDX_W-1:0] l_set = lkp_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] l_tag = lkp_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] f_set = fill_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] f_tag = fill_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] l_match, f_match;
  logic [1:0]      l_way, f_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign l_match[w] = vld[l_set][w] && (tags[l_set][w] == l_tag);
    assign f_match[w] = vld[f_set][w] && (tags[f_set][w] == f_tag);
  end

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    logic [2:0] n;
    n = p;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  function automatic logic [1:0] victim(input logic [2:0] p);
    return p[0] ? {1'b1, p[2]} : {1'b0, p[1]};
  endfunction

  always_comb begin
    l_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (l_match[w]) l_way = 2'(w);
  end

  always_comb begin
    f_way = victim(plru[f_set]);
    for (int w = WAYS-1; w >= 0; w--)
      if (!vld[f_set][w]) f_way = 2'(w);
    for (int w = 0; w < WAYS; w++)
      if (f_match[w]) f_way = 2'(w);
  end

  wire l_any = |l_match;
  wire f_go  = fill_en && !flush;
  wire l_upd = lkp_req && l_any && !flush && !(f_go && f_set == l_set);

  always_ff @(posedge clk)
    if (f_go) begin
      tags[f_set][f_way]  <= f_tag;
      words[f_set][f_way] <= fill_data;
    end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        plru[s] <= '0;
      end
    end else begin
      if (l_upd) plru[l_set] <= touch(plru[l_set], l_way);
      if (f_go) begin
        vld[f_set][f_way] <= 1'b1;
        plru[f_set]       <= touch(plru[f_set], f_way);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lkp_done <= 1'b0;
      lkp_hit  <= 1'b0;
      lkp_data <= '0;
    end else begin
      lkp_done <= lkp_req;
      lkp_hit  <= lkp_req && l_any && !flush;
      lkp_data <= (lkp_req && l_any && !flush) ? words[l_set][l_way] : '0;
    end
  end
endmodule

// File: rtl/walk_entry_cache_chk.sv
module walk_entry_cache_chk #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lkp_req,
  input logic [ADDR_W-1:0] lkp_addr,
  input logic              lkp_done,
  input logic              lkp_hit,
  input logic [DATA_W-1:0] lkp_data,
  input logic              fill_en,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [DATA_W-1:0] fill_data,
  input logic              flush,
  input logic [3:0]        l_match,
  input logic [3:0]        f_match
);
  assert_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> lkp_done);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> !lkp_done);
  assert_hit_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> lkp_done);
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_done && !lkp_hit) |-> lkp_data == '0);
  assert_refill_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_en && !flush) && lkp_req && !flush &&
     lkp_addr[ADDR_W-1:3] == $past(fill_addr[ADDR_W-1:3]))
    |=> (lkp_hit && lkp_data == $past(fill_data, 2)));
  assert_no_dup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_match) && $onehot0(f_match));
  assert_flush_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && lkp_req) |=> !lkp_hit);
  assert_flush_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && lkp_req) |=> !lkp_hit);
endmodule

bind walk_entry_cache walk_entry_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_addr(lkp_addr),
  .lkp_done(lkp_done), .lkp_hit(lkp_hit), .lkp_data(lkp_data),
  .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
  .flush(flush), .l_match(l_match), .f_match(f_match)
);

// File: tb/walk_entry_cache_bench.sv
module walk_entry_cache_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lkp_req = 0, fill_en = 0, flush = 0;
  logic [39:0] lkp_addr = '0, fill_addr = '0;
  logic [63:0] fill_data = '0;
  logic        lkp_done, lkp_hit;
  logic [63:0] lkp_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit          m_vld  [32][4];
  logic [31:0] m_tag  [32][4];
  logic [63:0] m_data [32][4];
  logic [2:0]  m_plru [32];

  always #5 clk = ~clk;

  walk_entry_cache u_walk_entry_cache (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_addr(lkp_addr),
    .lkp_done(lkp_done), .lkp_hit(lkp_hit), .lkp_data(lkp_data),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data), .flush(flush));

  function automatic logic [39:0] mk(int set, int tag, int low);
    return {32'(tag), 5'(set), 3'(low)};
  endfunction

  function automatic logic [2:0] m_touch(logic [2:0] p, int w);
    logic [2:0] n = p;
    n[0] = (w < 2);
    if (w < 2) n[1] = (w == 0);
    else       n[2] = (w == 2);
    return n;
  endfunction

  function automatic int m_victim(logic [2:0] p);
    if (!p[0]) return p[1] ? 1 : 0;
    return p[2] ? 3 : 2;
  endfunction

  function automatic int m_find(logic [39:0] a);
    for (int w = 0; w < 4; w++)
      if (m_vld[a[7:3]][w] && m_tag[a[7:3]][w] == a[39:8]) return w;
    return -1;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < 32; s++) begin
      m_plru[s] = '0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(string req, bit lr, logic [39:0] la, bit fe,
                    logic [39:0] fa, logic [63:0] fd, bit fl);
    int lw, fw;
    bit eh;
    logic [63:0] ed;
    @(negedge clk);
    lkp_req = lr; lkp_addr = la; fill_en = fe; fill_addr = fa; fill_data = fd; flush = fl;
    lw = m_find(la);
    eh = lr && lw >= 0 && !fl;
    ed = eh ? m_data[la[7:3]][lw] : 64'd0;
    if (fl) m_clear();
    else begin
      if (eh && !(fe && fa[7:3] == la[7:3]))
        m_plru[la[7:3]] = m_touch(m_plru[la[7:3]], lw);
      if (fe) begin
        fw = m_find(fa);
        if (fw < 0) begin
          fw = m_victim(m_plru[fa[7:3]]);
          for (int w = 3; w >= 0; w--) if (!m_vld[fa[7:3]][w]) fw = w;
        end
        m_vld[fa[7:3]][fw]  = 1;
        m_tag[fa[7:3]][fw]  = fa[39:8];
        m_data[fa[7:3]][fw] = fd;
        m_plru[fa[7:3]] = m_touch(m_plru[fa[7:3]], fw);
      end
    end
    @(negedge clk);
    if (lr) begin
      chk(req, "done", 64'(lkp_done), 64'd1);
      chk(req, "hit", 64'(lkp_hit), 64'(eh));
      chk(req, "data", lkp_data, ed);
    end else chk(req, "idle done", 64'(lkp_done), 64'd0);
    lkp_req = 0; fill_en = 0; flush = 0;
  endtask

  task automatic look(string req, logic [39:0] a);
    op(req, 1, a, 0, '0, '0, 0);
  endtask

  task automatic put(string req, logic [39:0] a, logic [63:0] d);
    op(req, 0, '0, 1, a, d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1", "done after reset", 64'(lkp_done), 64'd0);
    look("R1", mk(0, 1, 0));
    look("R1", mk(31, 0, 0));

    // R3 R4 hit through unaligned byte address, no aliasing across sets
    put("R3", mk(3, 9, 0), 64'hC0DE_0000_0000_0003);
    look("R4", mk(3, 9, 5));
    look("R4", mk(4, 9, 0));
    look("R4", mk(3, 8, 0));

    // R5 overwrite in place, then R6 lowest empty ways
    put("R5", mk(3, 9, 0), 64'hAAAA_5555_0000_0001);
    look("R5", mk(3, 9, 0));
    put("R6", mk(3, 10, 0), 64'h10);
    put("R6", mk(3, 11, 0), 64'h11);
    put("R6", mk(3, 12, 0), 64'h12);
    for (int t = 9; t <= 12; t++) look("R5", mk(3, t, 0));

    // R7 pseudo-LRU eviction
    for (int t = 1; t <= 4; t++) put("R7", mk(7, t, 0), 64'(t));
    put("R7", mk(7, 5, 0), 64'h5);
    for (int t = 1; t <= 5; t++) look("R7", mk(7, t, 0));
    look("R7", mk(7, 2, 0));
    put("R7", mk(7, 6, 0), 64'h6);
    for (int t = 2; t <= 6; t++) look("R7", mk(7, t, 0));

    // R9 lookup and fill together
    op("R9", 1, mk(9, 3, 0), 1, mk(9, 3, 0), 64'h99, 0);
    look("R9", mk(9, 3, 0));

    // R8 flush with coincident lookup and fill
    op("R8", 1, mk(9, 3, 0), 1, mk(10, 1, 0), 64'h1, 1);
    look("R8", mk(9, 3, 0));
    look("R8", mk(10, 1, 0));
    look("R8", mk(3, 9, 0));

    // R2 four chained lookups in consecutive cycles
    for (int s = 0; s < 4; s++) put("R2", mk(s + 12, s, 0), 64'hF00 + 64'(s));
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2", "chained done", 64'(lkp_done), 64'd1);
        chk("R2", "chained hit", 64'(lkp_hit), 64'd1);
        chk("R2", "chained data", lkp_data, 64'hF00 + 64'(i - 1));
      end
      lkp_req = (i < 4);
      lkp_addr = mk(i + 12, i, 0);
    end
    lkp_req = 0;

    // random traffic under eviction pressure
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom % 100;
      logic [39:0] a = mk($urandom % 4, $urandom % 6, $urandom % 8);
      logic [39:0] b = mk($urandom % 4, $urandom % 6, $urandom % 8);
      logic [63:0] d = {$urandom, $urandom};
      if (k < 45)      op("R7", 1, a, 0, '0, '0, 0);
      else if (k < 88) op("R5", 0, '0, 1, b, d, 0);
      else if (k < 98) op("R9", 1, a, 1, b, d, 0);
      else             op("R8", $urandom % 2, a, $urandom % 2, b, d, 1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule